// File: doc/BRIEF.md
# Staged Parallel Panel Command Port

This block lets a processor talk to a small display panel over a 16-bit parallel bus with separate write and read strobes. The processor does not drive the bus pins itself. It first places a transfer description in a staging register. A second register write, the trigger, then launches that transfer. The trigger word also chooses which of two attached panels is addressed.

Each transfer goes through three phases: a setup phase, a phase with the strobe held low, and a hold phase. Each phase lasts a fixed number of clocks set by a parameter, and each parameter must be at least 1. The panel chip select and the register-select line stay steady through all three phases.

A status flag tells software when the port is free to accept a new trigger. Triggers that arrive while the port is busy are dropped. Read data is captured when the read strobe is released and can then be read back from the read-data register.

Top module: `panel_cmd_bus`

## Requirements
- R1: After reset, both chip selects, the write strobe and the read strobe are high. The bus driver is off. The status word and the read-data word both read 0.
- R2: A write to address 0 stages a word. In that word, bit 28 marks a write, bit 24 sets register select (1 = data cycle, 0 = index cycle), and bits 15:0 are the bus value. A write to address 3 with bit 0 set launches the staged transfer. In that trigger word, bit 1 picks panel 1 (`pnl_cs_n[1]` low); bit 1 clear picks panel 0 (`pnl_cs_n[0]` low).
- R3: A transfer holds chip select and register select for SETUP_CYC + PULSE_CYC + HOLD_CYC clocks. Within that window, the strobe is low for exactly PULSE_CYC clocks, preceded by SETUP_CYC clocks and followed by HOLD_CYC clocks. The bus value stays steady throughout.
- R4: `pnl_doe` is high only during a write transfer, and `pnl_dout` then carries the staged bits 15:0. During a read, `pnl_doe` stays low.
- R5: A write to address 1 stages a read, with bit 24 setting register select. A write to address 4 with bit 0 set launches the read, and bit 1 picks the panel as in R2. `pnl_rd_n` is the strobe. The value on `pnl_din` in the last clock before `pnl_rd_n` rises is captured and read back in bits 15:0 of address 1.
- R6: Bit 1 of address 2 is the busy flag. It reads 1 from the clock after an accepted trigger and for SETUP_CYC + PULSE_CYC + HOLD_CYC clocks in total, then returns to 0.
- R7: A trigger written while busy has no effect. It changes neither the ongoing transfer nor the selected panel, and it does not queue a second transfer.
- R8: A write trigger is ignored when staged bit 28 is clear. Any trigger is ignored when its bit 0 is clear.
- R9: At most one chip select is low at any time, and a strobe is low only while a chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write enable |
| cpu_addr | input | 3 | Register address (0 stage write, 1 read data, 2 status, 3 write trigger, 4 read trigger) |
| cpu_wdata | input | 32 | Register write value |
| cpu_rdata | output | 32 | Register read value for `cpu_addr`, combinational |
| pnl_cs_n | output | 2 | Active-low chip selects, one per panel |
| pnl_rs | output | 1 | Register select: 1 data, 0 index |
| pnl_wr_n | output | 1 | Active-low write strobe |
| pnl_rd_n | output | 1 | Active-low read strobe |
| pnl_dout | output | 16 | Bus value driven toward the panel |
| pnl_doe | output | 1 | Bus driver enable |
| pnl_din | input | 16 | Bus value returned by the panel |

## Verification
The assertions assume software launches a trigger only by register writes and that `pnl_din` matters only while the read strobe is low. They make no assumption about trigger spacing, because the block itself must reject triggers that arrive while busy.

The stimulus obeys the busy protocol for normal transfers. It breaks that protocol on purpose only in the directed test for dropped triggers. The panel model drives the expected value on `pnl_din` while `pnl_rd_n` is low and the inverted value at all other times, so a capture taken a cycle too late shows up as a wrong read result.

// File: rtl/panel_cmd_bus.sv
module panel_cmd_bus #(
  parameter int SETUP_CYC = 2,
  parameter int PULSE_CYC = 3,
  parameter int HOLD_CYC  = 1,
  parameter int CNT_W     = 8,
  parameter int DW        = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_addr,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  output logic [1:0]    pnl_cs_n,
  output logic          pnl_rs,
  output logic          pnl_wr_n,
  output logic          pnl_rd_n,
  output logic [DW-1:0] pnl_dout,
  output logic          pnl_doe,
  input  logic [DW-1:0] pnl_din
);

  localparam logic [2:0] A_WDAT  = 3'd0;
  localparam logic [2:0] A_RDAT  = 3'd1;
  localparam logic [2:0] A_STAT  = 3'd2;
  localparam logic [2:0] A_WTRIG = 3'd3;
  localparam logic [2:0] A_RTRIG = 3'd4;
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(HOLD_CYC - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STRB, PH_HOLD} ph_t;

  ph_t              ph;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      wstage;
  logic             rd_rs;
  logic [DW-1:0]    rd_q;
  logic [DW-1:0]    op_data;
  logic             op_wr, op_rs, op_tgt;
  logic             busy, go_w, go_r, last;

  assign busy = (ph != PH_IDLE);
  assign last = (cnt == '0);
  assign go_w = cpu_wr && cpu_addr == A_WTRIG && cpu_wdata[0] && wstage[28] && !busy;
  assign go_r = cpu_wr && cpu_addr == A_RTRIG && cpu_wdata[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      wstage  <= '0;
      rd_rs   <= 1'b0;
      rd_q    <= '0;
      op_data <= '0;
      op_wr   <= 1'b0;
      op_rs   <= 1'b0;
      op_tgt  <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == A_WDAT) wstage <= cpu_wdata;
      if (cpu_wr && cpu_addr == A_RDAT) rd_rs  <= cpu_wdata[24];
      case (ph)
        PH_IDLE:
          if (go_w || go_r) begin
            ph      <= PH_SETUP;
            cnt     <= L_SETUP;
            op_wr   <= go_w;
            op_rs   <= go_w ? wstage[24] : rd_rs;
            op_data <= wstage[DW-1:0];
            op_tgt  <= cpu_wdata[1];
          end
        PH_SETUP:
          if (last) begin
            ph  <= PH_STRB;
            cnt <= L_PULSE;
          end else cnt <= cnt - 1'b1;
        PH_STRB:
          if (last) begin
            ph  <= PH_HOLD;
            cnt <= L_HOLD;
            if (!op_wr) rd_q <= pnl_din;
          end else cnt <= cnt - 1'b1;
        default:
          if (last) ph <= PH_IDLE;
          else cnt <= cnt - 1'b1;
      endcase
    end
  end

  always_comb begin
    case (cpu_addr)
      A_WDAT:  cpu_rdata = wstage;
      A_RDAT:  cpu_rdata = {{(32-DW){1'b0}}, rd_q};
      A_STAT:  cpu_rdata = {30'b0, busy, 1'b0};
      default: cpu_rdata = '0;
    endcase
  end

  assign pnl_cs_n = busy ? ~(2'b01 << op_tgt) : 2'b11;
  assign pnl_rs   = busy && op_rs;
  assign pnl_wr_n = !(ph == PH_STRB && op_wr);
  assign pnl_rd_n = !(ph == PH_STRB && !op_wr);
  assign pnl_doe  = busy && op_wr;
  assign pnl_dout = op_data;

endmodule

// File: rtl/panel_cmd_bus_chk.sv
module panel_cmd_bus_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic [1:0]    pnl_cs_n,
  input logic          pnl_rs,
  input logic          pnl_wr_n,
  input logic          pnl_rd_n,
  input logic          pnl_doe,
  input logic [DW-1:0] pnl_dout
);

  a_r9_one_panel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~pnl_cs_n));

  a_r9_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    (!pnl_wr_n || !pnl_rd_n) |-> pnl_cs_n != 2'b11);

  a_r4_quiet_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_rd_n |-> !pnl_doe && pnl_wr_n);

  a_r4_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_wr_n |-> pnl_doe && pnl_rd_n);

  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n && !pnl_doe);

  a_r3_steady_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(pnl_dout) && $stable(pnl_cs_n) && $stable(pnl_rs));

  a_r3_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pnl_wr_n) || $fell(pnl_rd_n)) |-> $past(pnl_cs_n) != 2'b11);

endmodule

bind panel_cmd_bus panel_cmd_bus_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .pnl_cs_n (pnl_cs_n),
  .pnl_rs   (pnl_rs),
  .pnl_wr_n (pnl_wr_n),
  .pnl_rd_n (pnl_rd_n),
  .pnl_doe  (pnl_doe),
  .pnl_dout (pnl_dout)
);

// File: tb/tb_panel_cmd_bus.sv
`timescale 1ns/1ps
module tb_panel_cmd_bus;
  localparam int S = 2, P = 3, H = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_addr = 3'd2;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [1:0]  pnl_cs_n;
  logic        pnl_rs, pnl_wr_n, pnl_rd_n, pnl_doe;
  logic [15:0] pnl_dout, pnl_din, rd_val = 16'h0;

  int n_chk = 0, n_fail = 0;
  int wr_cyc = 0, rd_cyc = 0, cs1_cyc = 0, act_cyc = 0;

  always #2.5 clk = ~clk;

  assign pnl_din = pnl_rd_n ? ~rd_val : rd_val;

  panel_cmd_bus #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pnl_cs_n(pnl_cs_n),
    .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n), .pnl_rd_n(pnl_rd_n),
    .pnl_dout(pnl_dout), .pnl_doe(pnl_doe), .pnl_din(pnl_din));

  always @(negedge clk) begin
    if (!pnl_wr_n) wr_cyc++;
    if (!pnl_rd_n) rd_cyc++;
    if (!pnl_cs_n[1]) cs1_cyc++;
    if (pnl_cs_n != 2'b11) act_cyc++;
  end

  // {is_read, rs, panel, data}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 1'b0, 1'b0, 16'h002C},
    {1'b0, 1'b1, 1'b0, 16'hA5F0},
    {1'b0, 1'b1, 1'b1, 16'hFFFF},
    {1'b0, 1'b0, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h3C5A},
    {1'b1, 1'b0, 1'b1, 16'h8001},
    {1'b1, 1'b1, 1'b1, 16'h0000}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpu_put(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 3'd2; cpu_wdata = '0;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic clr_cnt();
    wr_cyc = 0; rd_cyc = 0; cs1_cyc = 0; act_cyc = 0;
  endtask

  task automatic run_xfer(input bit is_rd, input bit rs, input bit tgt, input logic [15:0] d);
    int s = 0, p = 0, h = 0, n = 0;
    bit sig_ok = 1'b1, drv_ok = 1'b1;
    logic strb, other;
    rd_val = d;
    if (is_rd) cpu_put(3'd1, {7'b0, rs, 24'b0});
    else       cpu_put(3'd0, {3'b0, 1'b1, 3'b0, rs, 8'b0, d});
    cpu_put(is_rd ? 3'd4 : 3'd3, {30'b0, tgt, 1'b1});
    chk(cpu_rdata[1] == 1'b1, "R6 busy after trigger", {31'b0, cpu_rdata[1]}, 1);
    while (cpu_rdata[1] && n < 64) begin
      strb  = is_rd ? pnl_rd_n : pnl_wr_n;
      other = is_rd ? pnl_wr_n : pnl_rd_n;
      if (!strb) p++;
      else if (p == 0) s++;
      else h++;
      if (pnl_cs_n != (tgt ? 2'b01 : 2'b10) || pnl_rs != rs || !other) sig_ok = 1'b0;
      if (pnl_doe != !is_rd || (!is_rd && pnl_dout != d)) drv_ok = 1'b0;
      n++;
      @(negedge clk); #1;
    end
    chk(s == S, "R3 setup length", s, S);
    chk(p == P, "R3 strobe length", p, P);
    chk(h == H, "R3 hold length", h, H);
    chk(n == S + P + H, "R6 busy length", n, S + P + H);
    chk(sig_ok, is_rd ? "R5 select lines" : "R2 select lines", {30'b0, pnl_cs_n}, {31'b0, tgt});
    chk(drv_ok, "R4 bus drive", {15'b0, pnl_doe, pnl_dout}, {15'b0, !is_rd, d});
    if (is_rd) begin
      cpu_addr = 3'd1; #1;
      chk(cpu_rdata == {16'b0, d}, "R5 read data", cpu_rdata, {16'b0, d});
      cpu_addr = 3'd2; #1;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n && !pnl_doe, "R1 pins",
        {28'b0, pnl_cs_n, pnl_wr_n, pnl_rd_n}, 32'hF);
    chk(cpu_rdata == 0, "R1 status", cpu_rdata, 0);
    cpu_addr = 3'd1; #1;
    chk(cpu_rdata == 0, "R1 read data", cpu_rdata, 0);
    cpu_addr = 3'd2; #1;

    for (int i = 0; i < 7; i++)
      run_xfer(VEC[i][18], VEC[i][17], VEC[i][16], VEC[i][15:0]);

    // R7: triggers while busy are dropped
    idle(2);
    clr_cnt();
    cpu_put(3'd0, 32'h1000_1234);
    cpu_put(3'd3, 32'h1);
    cpu_put(3'd3, 32'h3);
    cpu_put(3'd4, 32'h3);
    idle(20);
    chk(cs1_cyc == 0, "R7 panel unchanged", cs1_cyc, 0);
    chk(wr_cyc == P, "R7 single write", wr_cyc, P);
    chk(rd_cyc == 0, "R7 no read", rd_cyc, 0);
    chk(act_cyc == S + P + H, "R7 one transfer", act_cyc, S + P + H);

    // R8: write staged without bit 28
    clr_cnt();
    cpu_put(3'd0, 32'h0100_5555);
    cpu_put(3'd3, 32'h1);
    idle(12);
    chk(act_cyc == 0 && wr_cyc == 0, "R8 no write flag", act_cyc, 0);
    // R8: trigger bit 0 clear
    clr_cnt();
    cpu_put(3'd0, 32'h1100_5555);
    cpu_put(3'd3, 32'h2);
    cpu_put(3'd4, 32'h2);
    idle(12);
    chk(act_cyc == 0 && wr_cyc == 0 && rd_cyc == 0, "R8 no start bit", act_cyc, 0);
    chk(cpu_rdata[1] == 1'b0, "R8 busy stays low", cpu_rdata, 0);

    // R2 after ignored triggers the staged word still launches
    run_xfer(1'b0, 1'b1, 1'b0, 16'h5555);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule